// File: doc/BRIEF.md
# UART Transmit Queue with Half-Level Interrupt

This block is the transmit side of a UART-style peripheral. A host pushes bytes into a 32-entry queue through a one-cycle write strobe. The serializer reads the oldest byte from a show-ahead data output and removes it with a pop strobe. The block reports queue state on three flags: busy, full and empty. It also keeps a sticky overflow bit.

The transmit interrupt works around a trigger level at half the queue depth. The raw status bit goes high when a queue change leaves 16 or fewer entries occupied. At that point the host can always write at least 16 more bytes without losing any. The bit drops when writes push the occupancy above the trigger level, or when the host pulses the clear input. The full flag is kept separate from the interrupt. A host-written enable bit gates the raw status onto the interrupt output.

All status outputs come from registers. Each one reflects the queue after the clock edge that sampled the strobes.

Top module: `uart_txq_trig`

## Requirements
- R1: After reset: the queue is empty, `stat_empty_o`=1, `stat_busy_o`=0, `stat_full_o`=0, `stat_ovf_o`=0, `raw_irq_o`=1, the mask is 0 and `irq_o`=0.
- R2: Bytes leave in the order they were accepted. While the queue is not empty, `drain_data_o` shows the oldest entry. A pop while the queue is empty is ignored.
- R3: `stat_full_o` is 1 exactly when 32 entries are held. It clears after any pop that is not paired with a push.
- R4: A write while the queue is full and no pop is accepted in the same cycle is dropped. The queue contents do not change, and `stat_ovf_o` becomes 1 and stays 1 until reset.
- R5: An accepted write leaves `stat_empty_o`=0 and `stat_busy_o`=1. The edge that pops the last entry sets `stat_empty_o`=1 and `stat_busy_o`=0.
- R6: `raw_irq_o` is 0 whenever the occupancy is above 16.
- R7: An accepted push or pop that leaves the occupancy at 16 or below sets `raw_irq_o`.
- R8: `irq_clr_i` clears `raw_irq_o` when no push or pop is accepted in that cycle. If a pop or push that sets the bit (R7) happens in the same cycle, the bit stays set.
- R9: `irq_o` equals `raw_irq_o` AND the mask bit. The mask bit is loaded from `mask_wdata_i` when `mask_we_i` is 1.
- R10: A push and a pop accepted in the same cycle leave the occupancy unchanged. A push is accepted when the queue is full if a pop is accepted in the same cycle. Flags and interrupt are evaluated on that unchanged occupancy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Byte to queue |
| irq_clr_i | input | 1 | Clear raw transmit interrupt |
| mask_we_i | input | 1 | Load interrupt mask bit |
| mask_wdata_i | input | 1 | New mask bit value |
| drain_pop_i | input | 1 | Serializer pop strobe |
| drain_data_o | output | 8 | Oldest queued byte (show-ahead) |
| stat_busy_o | output | 1 | Queue holds data |
| stat_full_o | output | 1 | Queue holds 32 entries |
| stat_empty_o | output | 1 | Queue holds no entries |
| stat_ovf_o | output | 1 | Sticky dropped-write status |
| raw_irq_o | output | 1 | Raw transmit interrupt |
| irq_o | output | 1 | Masked transmit interrupt |

## Verification
Every status output and the head byte are registered. Each result is due exactly one clock after the edge that sampled its strobe, and shows no change before that edge. The bench drives inputs on the falling edge and updates its queue model on the rising edge. It compares all outputs on the next falling edge, so each comparison lands one cycle after its stimulus. Reset release passes through a two-stage synchronizer. The bench therefore holds all strobes idle for several cycles after releasing reset, during which the reset state is unchanged.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
  localparam int unsigned TXQ_DATA_W = 8;
  localparam int unsigned TXQ_DEPTH  = 32;

  typedef struct packed {
    logic busy;
    logic full;
    logic empty;
    logic ovf;
  } txq_flags_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              push_ok,
  output logic              pop_ok,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_d
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic              is_full, is_empty;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    is_full  = (cnt_q == CNT_W'(DEPTH));
    is_empty = (cnt_q == '0);
    pop_ok   = rd_req && !is_empty;
    push_ok  = wr_req && (!is_full || pop_ok);
    wr_ptr_d = push_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    rd_data  = mem_q[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_pair_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(cnt_q));
  assert_empty_pop_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cnt_q == '0 && !wr_req) |=> (cnt_q == '0));
endmodule

// File: rtl/txq_irq_ctrl.sv
module txq_irq_ctrl
  import uart_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned TRIG  = DEPTH / 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             irq_clr,
  input  logic             mask_we,
  input  logic             mask_wdata,
  output txq_flags_t       flags,
  output logic             raw_irq,
  output logic             irq
);
  txq_flags_t flg_q, flg_d;
  logic       raw_q, raw_d, mask_q, mask_d;
  logic       above_trig;

  always_comb begin
    above_trig  = (cnt_d > CNT_W'(TRIG));
    flg_d.full  = (cnt_d == CNT_W'(DEPTH));
    flg_d.empty = (cnt_d == '0);
    flg_d.busy  = (cnt_d != '0);
    flg_d.ovf   = flg_q.ovf || (wr_req && !push_ok);
    if (above_trig)             raw_d = 1'b0;
    else if (push_ok || pop_ok) raw_d = 1'b1;
    else if (irq_clr)           raw_d = 1'b0;
    else                        raw_d = raw_q;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q  <= '{busy: 1'b0, full: 1'b0, empty: 1'b1, ovf: 1'b0};
      raw_q  <= 1'b1;
      mask_q <= 1'b0;
    end else begin
      flg_q  <= flg_d;
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign flags   = flg_q;
  assign raw_irq = raw_q;
  assign irq     = raw_q && mask_q;

  assert_full_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q.full == (cnt_q == CNT_W'(DEPTH)));
  assert_empty_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q.empty == (cnt_q == '0)) && (flg_q.busy != flg_q.empty));
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q.ovf |=> flg_q.ovf);
  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !push_ok) |=> flg_q.ovf);
  assert_low_above_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CNT_W'(TRIG)) |-> !raw_q);
  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !push_ok && !pop_ok) |=> !raw_q);
  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && pop_ok && cnt_d <= CNT_W'(TRIG)) |=> raw_q);
endmodule

// File: rtl/uart_txq_trig.sv
module uart_txq_trig
  import uart_txq_pkg::*;
#(
  parameter int unsigned DATA_W = TXQ_DATA_W,
  parameter int unsigned DEPTH  = TXQ_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              irq_clr_i,
  input  logic              mask_we_i,
  input  logic              mask_wdata_i,
  input  logic              drain_pop_i,
  output logic [DATA_W-1:0] drain_data_o,
  output logic              stat_busy_o,
  output logic              stat_full_o,
  output logic              stat_empty_o,
  output logic              stat_ovf_o,
  output logic              raw_irq_o,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             push_ok, pop_ok;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  txq_flags_t       flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_req  (host_wr_i),
    .wr_data (host_wdata_i),
    .rd_req  (drain_pop_i),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .rd_data (drain_data_o),
    .cnt_q   (cnt_q),
    .cnt_d   (cnt_d)
  );

  txq_irq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_req     (host_wr_i),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .cnt_q      (cnt_q),
    .cnt_d      (cnt_d),
    .irq_clr    (irq_clr_i),
    .mask_we    (mask_we_i),
    .mask_wdata (mask_wdata_i),
    .flags      (flags),
    .raw_irq    (raw_irq_o),
    .irq        (irq_o)
  );

  assign stat_busy_o  = flags.busy;
  assign stat_full_o  = flags.full;
  assign stat_empty_o = flags.empty;
  assign stat_ovf_o   = flags.ovf;

  assert_mask_gate_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_o |-> raw_irq_o);
endmodule

// File: tb/uart_txq_trig_bench.sv
module uart_txq_trig_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, clr = 1'b0, mwe = 1'b0, md = 1'b0, rd = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] dout;
  logic       busy, full, empty, ovf, raw, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] q[$];
  bit m_raw, m_ovf, m_mask;

  always #10 clk = ~clk;

  uart_txq_trig u_uart_txq_trig (
    .clk(clk), .rst_n(rst_n), .host_wr_i(wr), .host_wdata_i(wd),
    .irq_clr_i(clr), .mask_we_i(mwe), .mask_wdata_i(md), .drain_pop_i(rd),
    .drain_data_o(dout), .stat_busy_o(busy), .stat_full_o(full),
    .stat_empty_o(empty), .stat_ovf_o(ovf), .raw_irq_o(raw), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of bytes plus three status bits
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_raw = 1; m_ovf = 0; m_mask = 0;
    end else begin
      bit pop_a, push_a;
      pop_a  = rd && q.size() > 0;
      push_a = wr && (q.size() < 32 || pop_a);
      if (pop_a) void'(q.pop_front());
      if (push_a) q.push_back(wd);
      if (wr && !push_a) m_ovf = 1;
      if (q.size() > 16) m_raw = 0;
      else if (push_a || pop_a) m_raw = 1;
      else if (clr) m_raw = 0;
      if (mwe) m_mask = md;
    end
  end

  // Per-cycle comparison, half a period after each edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(full == (q.size() == 32), "R3 full", full, q.size() == 32);
      chk(empty == (q.size() == 0), "R5 empty", empty, q.size() == 0);
      chk(busy == (q.size() != 0), "R5 busy", busy, q.size() != 0);
      chk(ovf == m_ovf, "R4 ovf", ovf, m_ovf);
      chk(raw == m_raw, "R7 raw", raw, m_raw);
      chk(irq == (m_raw && m_mask), "R9 irq", irq, m_raw && m_mask);
      if (q.size() > 0) chk(dout == q[0], "R2 head", dout, q[0]);
    end
  end

  task automatic cyc(input bit w, input logic [7:0] d, input bit r, input bit c);
    wr = w; wd = d; rd = r; clr = c;
    @(posedge clk); @(negedge clk);
    wr = 0; rd = 0; clr = 0; mwe = 0;
  endtask

  initial begin
    #(200000 * 20);
    $display("FAIL watchdog: actual 1 expected 0");
    errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(empty && !busy && !full && !ovf, "R1 flags", {busy, full, empty, ovf}, 4'b0010);
    chk(raw == 1 && irq == 0, "R1 irq", {raw, irq}, 2'b10);

    mwe = 1; md = 1; cyc(0, 0, 0, 0);
    chk(irq == 1, "R9 mask on", irq, 1);

    // R6: fill to 17 drops the raw bit
    for (int i = 0; i < 16; i++) cyc(1, 8'(i + 1), 0, 0);
    chk(raw == 1, "R7 at 16", raw, 1);
    cyc(1, 8'd17, 0, 0);
    chk(raw == 0, "R6 at 17", raw, 0);
    for (int i = 17; i < 32; i++) cyc(1, 8'(i + 1), 0, 0);
    chk(full == 1, "R3 at 32", full, 1);

    // R4 overflow drop
    cyc(1, 8'hEE, 0, 0);
    chk(ovf == 1 && dout == 8'd1, "R4 drop", {ovf, dout}, {1'b1, 8'd1});

    // R10 push+pop while full
    cyc(1, 8'h55, 1, 0);
    chk(full == 1 && dout == 8'd2, "R10 pair", {full, dout}, {1'b1, 8'd2});
    chk(ovf == 1, "R4 sticky", ovf, 1);

    cyc(0, 0, 1, 0);
    chk(full == 0, "R3 clears", full, 0);

    // Drain to 17, then one pop reaching 16 with a coincident clear
    for (int i = 0; i < 14; i++) cyc(0, 0, 1, 0);
    chk(raw == 0, "R6 at 17 drain", raw, 0);
    cyc(0, 0, 1, 1);
    chk(raw == 1, "R8 set beats clear", raw, 1);
    cyc(0, 0, 0, 1);
    chk(raw == 0, "R8 idle clear", raw, 0);
    cyc(0, 0, 1, 0);
    chk(raw == 1, "R7 drain set", raw, 1);
    mwe = 1; md = 0; cyc(0, 0, 0, 0);
    chk(irq == 0 && raw == 1, "R9 masked", {irq, raw}, 2'b01);

    // Drain to empty and pop once more
    for (int i = 0; i < 15; i++) cyc(0, 0, 1, 0);
    chk(empty == 1 && busy == 0, "R5 last pop", {empty, busy}, 2'b10);
    cyc(0, 0, 1, 0);
    chk(empty == 1, "R2 empty pop", empty, 1);
    cyc(1, 8'h77, 1, 0);
    chk(dout == 8'h77 && busy == 1, "R10 empty pair", {busy, dout}, {1'b1, 8'h77});

    // Random traffic, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      mwe = ($urandom_range(0, 15) == 0); md = $urandom_range(0, 1);
      cyc($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 99) < 45,
          $urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule